// File: doc/BRIEF.md
# Hit Timestamp Assembler for a Delay-Line TDC Channel

This block forms the timestamp of one time-to-digital converter channel. A coarse time comes from a 9-bit count of reference clock periods. A fine time comes from a snapshot of a 32-stage delay line that spans one reference period. The analog front end supplies three things at the moment of a hit: an asynchronous hit strobe, the tap snapshot, and the level of the reference clock sampled by that hit. The block returns a 16-bit word in the reference clock domain and a one-cycle valid strobe. A consumer acknowledges each word before the next hit can replace it.

A hit is asynchronous, so it can land while a coarse counter is changing. To avoid reading a counter at that moment, the block keeps two counters. One advances on the rising edge of the reference clock and the other on the falling edge. The sampled clock level picks whichever counter is settled at that instant. The rising-edge counter is then corrected by one so that both paths report the same period index.

The snapshot is read as a circular thermometer pattern, and the fine code is the position of its single falling transition. A malformed pattern is flagged, not guessed.

Top module: `tdc_timestamp`

## Requirements
- R1: While `rstN` is low, `tsWord` is 0 and `tsValid` is 0.
- R2: For a hit while `clkSample` is 1, the coarse field equals (number of `refClk` rising edges since reset release minus 1) modulo 512. This value is taken from the falling-edge counter.
- R3: For a hit while `clkSample` is 0, the coarse field takes the same value as in R2, taken from the rising-edge counter minus 1.
- R4: The fine field is the index i (0 to 31) for which `tapSnap[i]` is 1 and `tapSnap[(i+1) mod 32]` is 0, when exactly one such index exists.
- R5: If no such index exists, or more than one does, bit 14 (error) is 1 and the fine field is 0. The coarse field is still filled as in R2 and R3.
- R6: Word layout: bits 4:0 hold the fine field, bits 13:5 the coarse field, bit 14 the error flag and bit 15 the hold flag.
- R7: An accepted hit that arrives between rising edges n and n+1 loads `tsWord` and raises `tsValid` at rising edge n+3. `tsValid` stays high for exactly one cycle.
- R8: A hit that arrives while the last word is unacknowledged is dropped. Bits 14:0 of `tsWord` keep their value, bit 15 becomes 1 at the edge where the dropped hit would have loaded, and `tsValid` stays 0.
- R9: A one-cycle `readAck` pulse marks the word as read. The next hit is then accepted and loads a word with bit 15 cleared.
- R10: Both coarse counters wrap from 511 to 0 with no other indication, so coarse fields continue from 0 after 512 periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock; coarse time base |
| rstN | input | 1 | Asynchronous active-low reset |
| hitStrobe | input | 1 | Asynchronous hit; rising edge marks the hit instant |
| tapSnap | input | 32 | Delay-line tap levels latched at the hit |
| clkSample | input | 1 | Reference clock level latched at the hit |
| readAck | input | 1 | Consumer has read the current word |
| tsWord | output | 16 | Timestamp word (fine, coarse, error, hold) |
| tsValid | output | 1 | One-cycle strobe for a newly loaded word |

## Verification
The checker watches four properties on every reference clock cycle:
- the rising-edge counter steps by one and wraps;
- an error word carries a zero fine field;
- the valid strobe never lasts more than one cycle and only fires when the previous word was already acknowledged;
- a rising hold flag leaves the rest of the word untouched.

Whether the chosen counter yields the right period index only shows up against hit times, so that is left to the bench. The same goes for the fine code at each bin, including hits one bin either side of each clock edge, and for the three-edge load latency. The bench model derives each expected word from the hit instant alone and compares the word and the strobe on every cycle.

// File: rtl/tdc_ts_pkg.sv
`timescale 1ps/1ps
package tdc_ts_pkg;
  // Strobes from control to datapath, valid for one refClk cycle.
  typedef struct packed {
    logic load;      // capture the pending hit into the output word
    logic markHold;  // a hit was dropped; flag it in the held word
  } tsStrobes_t;
endpackage

// File: rtl/tdc_ts_ctrl.sv
`timescale 1ps/1ps
module tdc_ts_ctrl
  import tdc_ts_pkg::*;
(
  input  logic       refClk,
  input  logic       rstN,
  input  logic       hitStrobe,
  input  logic       readAck,
  output tsStrobes_t strobes,
  output logic       unread
);
  logic hitTgl;
  logic syncA, syncB, seenTgl;
  logic hitPulse;

  // One toggle per hit; crosses into refClk through two flops.
  always_ff @(posedge hitStrobe or negedge rstN) begin
    if (!rstN) hitTgl <= 1'b0;
    else       hitTgl <= ~hitTgl;
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= 1'b0;
      syncB   <= 1'b0;
      seenTgl <= 1'b0;
    end else begin
      syncA   <= hitTgl;
      syncB   <= syncA;
      seenTgl <= syncB;
    end
  end

  assign hitPulse         = syncB ^ seenTgl;
  assign strobes.load     = hitPulse & ~unread;
  assign strobes.markHold = hitPulse & unread;

  // A fresh load has priority over an acknowledge in the same cycle.
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)             unread <= 1'b0;
    else if (strobes.load) unread <= 1'b1;
    else if (readAck)      unread <= 1'b0;
  end
endmodule

// File: rtl/tdc_ts_datapath.sv
`timescale 1ps/1ps
module tdc_ts_datapath
  import tdc_ts_pkg::*;
#(
  parameter int COARSE_W = 9,
  parameter int TAPS     = 32,
  localparam int FINE_W  = $clog2(TAPS),
  localparam int WORD_W  = FINE_W + COARSE_W + 2
) (
  input  logic                refClk,
  input  logic                rstN,
  input  logic                hitStrobe,
  input  logic [TAPS-1:0]     tapSnap,
  input  logic                clkSample,
  input  tsStrobes_t          strobes,
  output logic [WORD_W-1:0]   tsWord,
  output logic                tsValid,
  output logic [COARSE_W-1:0] cntRise,
  output logic [COARSE_W-1:0] cntFall
);
  logic [TAPS-1:0]     fallEdge;
  logic [FINE_W:0]     edgeCount;
  logic [FINE_W-1:0]   edgeIndex;
  logic                encErr;
  logic [FINE_W-1:0]   encFine;
  logic [COARSE_W-1:0] selCoarse;
  logic [FINE_W-1:0]   capFine;
  logic [COARSE_W-1:0] capCoarse;
  logic                capErr;

  // Offset coarse counters; each wraps silently.
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) cntRise <= '0;
    else       cntRise <= cntRise + 1'b1;
  end

  always_ff @(negedge refClk or negedge rstN) begin
    if (!rstN) cntFall <= '0;
    else       cntFall <= cntFall + 1'b1;
  end

  // Circular 1->0 transition detector over the tap ring.
  for (genvar g = 0; g < TAPS; g++) begin : g_edge
    assign fallEdge[g] = tapSnap[g] & ~tapSnap[(g + 1) % TAPS];
  end

  always_comb begin
    edgeIndex = '0;
    for (int i = 0; i < TAPS; i++) begin
      if (fallEdge[i]) edgeIndex = edgeIndex | FINE_W'(i);
    end
  end

  assign edgeCount = (FINE_W + 1)'($countones(fallEdge));
  assign encErr    = (edgeCount != (FINE_W + 1)'(1));
  assign encFine   = encErr ? '0 : edgeIndex;

  // High level: falling-edge counter is settled. Low level: use the
  // rising-edge counter, one step ahead, pulled back to the same index.
  assign selCoarse = clkSample ? cntFall : (cntRise - 1'b1);

  always_ff @(posedge hitStrobe or negedge rstN) begin
    if (!rstN) begin
      capFine   <= '0;
      capCoarse <= '0;
      capErr    <= 1'b0;
    end else begin
      capFine   <= encFine;
      capCoarse <= selCoarse;
      capErr    <= encErr;
    end
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      tsWord  <= '0;
      tsValid <= 1'b0;
    end else begin
      tsValid <= strobes.load;
      if (strobes.load)
        tsWord <= {1'b0, capErr, capCoarse, capFine};
      else if (strobes.markHold)
        tsWord[WORD_W-1] <= 1'b1;
    end
  end
endmodule

// File: rtl/tdc_timestamp.sv
`timescale 1ps/1ps
module tdc_timestamp
  import tdc_ts_pkg::*;
#(
  parameter int COARSE_W = 9,
  parameter int TAPS     = 32,
  localparam int FINE_W  = $clog2(TAPS),
  localparam int WORD_W  = FINE_W + COARSE_W + 2
) (
  input  logic              refClk,
  input  logic              rstN,
  input  logic              hitStrobe,
  input  logic [TAPS-1:0]   tapSnap,
  input  logic              clkSample,
  input  logic              readAck,
  output logic [WORD_W-1:0] tsWord,
  output logic              tsValid
);
  tsStrobes_t          strobes;
  logic                unread;
  logic [COARSE_W-1:0] cntRise;
  logic [COARSE_W-1:0] cntFall;

  tdc_ts_ctrl ctrl_i (
    .refClk    (refClk),
    .rstN      (rstN),
    .hitStrobe (hitStrobe),
    .readAck   (readAck),
    .strobes   (strobes),
    .unread    (unread)
  );

  tdc_ts_datapath #(.COARSE_W(COARSE_W), .TAPS(TAPS)) dp_i (
    .refClk    (refClk),
    .rstN      (rstN),
    .hitStrobe (hitStrobe),
    .tapSnap   (tapSnap),
    .clkSample (clkSample),
    .strobes   (strobes),
    .tsWord    (tsWord),
    .tsValid   (tsValid),
    .cntRise   (cntRise),
    .cntFall   (cntFall)
  );
endmodule

// File: rtl/tdc_timestamp_chk.sv
`timescale 1ps/1ps
module tdc_timestamp_chk #(
  parameter int COARSE_W = 9,
  parameter int TAPS     = 32,
  localparam int FINE_W  = $clog2(TAPS),
  localparam int WORD_W  = FINE_W + COARSE_W + 2
) (
  input logic                refClk,
  input logic                rstN,
  input logic [WORD_W-1:0]   tsWord,
  input logic                tsValid,
  input logic                unread,
  input logic [COARSE_W-1:0] cntRise
);
  localparam logic [COARSE_W-1:0] CNT_MAX = '1;

  a_r10_no_overflow: assert property (@(posedge refClk) disable iff (!rstN)
    (cntRise == CNT_MAX) |=> (cntRise == '0));

  a_r10_step: assert property (@(posedge refClk) disable iff (!rstN)
    1'b1 |=> (cntRise == $past(cntRise) + 1'b1));

  a_r5_err_zero_fine: assert property (@(posedge refClk) disable iff (!rstN)
    tsWord[WORD_W-2] |-> (tsWord[FINE_W-1:0] == '0));

  a_r7_single_valid: assert property (@(posedge refClk) disable iff (!rstN)
    tsValid |=> !tsValid);

  a_r8_valid_needs_read: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(tsValid) |-> !$past(unread));

  a_r8_hold_keeps_word: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(tsWord[WORD_W-1]) |-> (tsWord[WORD_W-2:0] == $past(tsWord[WORD_W-2:0])));

  a_r9_valid_sets_unread: assert property (@(posedge refClk) disable iff (!rstN)
    tsValid |-> unread);
endmodule

bind tdc_timestamp tdc_timestamp_chk #(.COARSE_W(COARSE_W), .TAPS(TAPS)) chk_i (
  .refClk  (refClk),
  .rstN    (rstN),
  .tsWord  (tsWord),
  .tsValid (tsValid),
  .unread  (unread),
  .cntRise (cntRise)
);

// File: tb/tdc_timestamp_tb_top.sv
`timescale 1ps/1ps
module tdc_timestamp_tb_top;
  localparam int PERIOD = 10000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hitStrobe = 1'b0;
  logic [31:0] tapSnap = '0;
  logic        clkSample = 1'b0;
  logic        readAck = 1'b0;
  logic [15:0] tsWord;
  logic        tsValid;

  int    checkCount = 0;
  int    failCount  = 0;
  int    edgeCount  = 0;
  bit    done = 1'b0;
  bit    checking = 1'b0;

  // Reference model state
  int          evCycle[$];
  logic [15:0] evWord[$];
  string       evTag[$];
  logic [15:0] expWord = '0;
  logic        expValid = 1'b0;
  logic        expUnread = 1'b0;
  string       curTag = "R2";

  tdc_timestamp dut_i (
    .refClk(clk), .rstN(rstN), .hitStrobe(hitStrobe), .tapSnap(tapSnap),
    .clkSample(clkSample), .readAck(readAck), .tsWord(tsWord), .tsValid(tsValid)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Model: advances on each rising edge from the hit instants alone.
  always @(posedge clk) begin
    if (rstN) begin
      edgeCount++;
      expValid = 1'b0;
      if (evCycle.size() > 0 && evCycle[0] == edgeCount) begin
        if (!expUnread) begin
          expWord  = evWord[0];
          expValid = 1'b1;
          curTag   = evTag[0];
          expUnread = 1'b1;
        end else begin
          expWord[15] = 1'b1;
          if (readAck) expUnread = 1'b0;
        end
        void'(evCycle.pop_front());
        void'(evWord.pop_front());
        void'(evTag.pop_front());
      end else if (readAck) begin
        expUnread = 1'b0;
      end
    end
  end

  // Compare every cycle, away from the rising edge.
  always @(negedge clk) begin
    if (checking) begin
      chk(tsValid == expValid, "R7", "valid", tsValid, expValid);
      chk(tsWord[4:0] == expWord[4:0], expWord[14] ? "R5" : "R4", "fine",
          tsWord[4:0], expWord[4:0]);
      chk(tsWord[13:5] == expWord[13:5], curTag, "coarse", tsWord[13:5], expWord[13:5]);
      chk(tsWord[14] == expWord[14], "R5", "error bit", tsWord[14], expWord[14]);
      chk(tsWord[15] == expWord[15], expWord[15] ? "R8" : "R9", "hold bit",
          tsWord[15], expWord[15]);
      chk(tsWord == expWord, "R6", "whole word", tsWord, expWord);
    end
  end

  // kind: 0 clean ring pattern, 1 all zeros, 2 all ones, 3 two transitions
  task automatic doHit(input int phase, input int kind);
    int n, f;
    logic [31:0] t;
    logic err;
    logic [8:0] crs;
    string tag;
    @(posedge clk);
    #(phase);
    n = edgeCount;
    f = (phase * 32) / PERIOD;
    t = '0;
    err = 1'b0;
    case (kind)
      0: for (int k = 0; k < 16; k++) t[(f - k + 32) % 32] = 1'b1;
      1: begin t = 32'h0000_0000; err = 1'b1; end
      2: begin t = 32'hFFFF_FFFF; err = 1'b1; end
      default: begin t = 32'h0000_0F0F; err = 1'b1; end
    endcase
    crs = 9'((n - 1) % 512);
    if (n - 1 >= 512) tag = "R10";
    else if (phase < PERIOD/2) tag = "R2";
    else tag = "R3";
    evCycle.push_back(n + 3);
    evWord.push_back({1'b0, err, crs, err ? 5'd0 : 5'(f)});
    evTag.push_back(tag);
    tapSnap   = t;
    clkSample = clk;
    hitStrobe = 1'b1;
    #2000;
    hitStrobe = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk);
    readAck = 1'b1;
    @(negedge clk);
    readAck = 1'b0;
  endtask

  task automatic hitAndRead(input int phase, input int kind);
    doHit(phase, kind);
    repeat (4) @(posedge clk);
    ack();
  endtask

  initial begin
    int p;
    int edgePhases[14] = '{1, 156, 312, 313, 2500, 4687, 4688, 4999,
                           5001, 5312, 7000, 9687, 9688, 9999};
    repeat (3) @(negedge clk);
    chk(tsWord == 16'd0, "R1", "word in reset", tsWord, 0);
    chk(tsValid == 1'b0, "R1", "valid in reset", tsValid, 0);
    #(PERIOD/4);
    rstN = 1'b1;
    checking = 1'b1;
    repeat (3) @(posedge clk);

    // Hits at and near both clock edges (R2, R3, R4)
    foreach (edgePhases[i]) hitAndRead(edgePhases[i], 0);

    // Malformed snapshots (R5)
    hitAndRead(3000, 1);
    hitAndRead(6000, 2);
    hitAndRead(8000, 3);

    // Drop while unread, then recover after acknowledge (R8, R9)
    doHit(2000, 0);
    repeat (5) @(posedge clk);
    doHit(7000, 0);
    repeat (5) @(posedge clk);
    ack();
    hitAndRead(4000, 0);

    // Random hits across wrap of the coarse count (R10)
    for (int i = 0; i < 150; i++) begin
      p = $urandom_range(1, PERIOD - 1);
      if (p == PERIOD/2) p = PERIOD/2 + 1;
      hitAndRead(p, ($urandom_range(0, 9) == 0) ? 3 : 0);
    end
    chk(edgeCount > 600, "R10", "periods covered past wrap", edgeCount, 601);

    repeat (5) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end
endmodule